// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Selectable Read Pipeline

This block is a true dual-port memory of 4096 words of nine bits. Each of its two ports, left and right, has its own address, write data, read/write select, active-low chip select, active-low clock enable and an asynchronous active-low output enable. Both ports may read or write the array in the same clock cycle. Each port samples its requests on the rising clock edge. A clock enable held high freezes that port for the cycle: nothing is written and its output state is kept.

Read data comes back through one of two paths. The flow-through path shows the word right after the edge that sampled the read. The pipelined path adds one more register stage. The left port always uses the pipelined path. The right port picks its path from a static mode input. Pads are modelled as a data bus plus a drive flag. The flag is high only when the slot belongs to a read and the output enable is low. If both ports write the same word in one cycle, the left data wins and a clash flag pulses.

Top module: `dpram_dual`

## Requirements
- R1: While reset is high and after it is released, both drive flags and the clash flag are low until a read is sampled.
- R2: A port with clock enable low, chip select low and read/write low at a rising edge stores its write data at its address. Its output slot for that edge is not driven.
- R3: In flow-through mode (right port, mode input 0), a read sampled at an edge has its word and a high drive flag from that edge on.
- R4: In pipelined mode (left port always, right port with mode input 1), the word of a read sampled at edge k appears at edge k+1.
- R5: A clock enable high at an edge makes the port ignore that edge. No write happens, and the output data and drive flag keep their values.
- R6: A chip select high at an edge undrives that port's output from that slot on. In pipelined mode the output is driven again only after chip select is low at two consecutive sampled edges, the first of which is a read.
- R7: The output enable acts without a clock. While it is high the drive flag is low, and it returns as soon as the enable goes low again.
- R8: If one port writes an address at the edge where the other port reads it, the read returns the old word. The next read returns the new word.
- R9: If both ports write the same address at one edge, the left word is stored and the clash flag is high for the following cycle only.
- R10: Accesses of the two ports to any mix of addresses, under random mixed traffic with stalls and output-enable toggling, match a behavioural memory model on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset of control and output state |
| l_addr | input | 12 | Left port word address |
| l_wdat | input | 9 | Left port write data |
| l_rw_n | input | 1 | Left port read (1) / write (0) select |
| l_ce_n | input | 1 | Left port chip select, active low |
| l_cke_n | input | 1 | Left port clock enable, active low |
| l_oe_n | input | 1 | Left port asynchronous output enable, active low |
| l_rdat | output | 9 | Left port read data (pipelined) |
| l_rdat_vld | output | 1 | Left port output drive flag |
| r_addr | input | 12 | Right port word address |
| r_wdat | input | 9 | Right port write data |
| r_rw_n | input | 1 | Right port read (1) / write (0) select |
| r_ce_n | input | 1 | Right port chip select, active low |
| r_cke_n | input | 1 | Right port clock enable, active low |
| r_oe_n | input | 1 | Right port asynchronous output enable, active low |
| r_pipe | input | 1 | Right port read path: 1 pipelined, 0 flow-through |
| r_rdat | output | 9 | Right port read data |
| r_rdat_vld | output | 1 | Right port output drive flag |
| wr_clash | output | 1 | One-cycle pulse after both ports wrote one address |

## Verification
Some rules are checked by the assertions on every cycle. A write slot never raises the flow-through drive state. A deselect undrives it. A stalled edge leaves the whole output pipeline untouched. The pipelined drive flag rises only after a read was in flight. A clash cycle finds the left word in the array. Other behaviour can only be shown by the bench's scenarios. This covers the exact cycle in which data appears on each path, the old-word result of a read colliding with a write, and the output enable acting without a clock. It also covers data integrity across both ports under random traffic.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } port_op_e;

  function automatic port_op_e op_of(input logic ce_n, input logic rw_n);
    if (ce_n) return OP_IDLE;
    return rw_n ? OP_READ : OP_WRITE;
  endfunction

endpackage

// File: rtl/dpram_array.sv
module dpram_array #(
  parameter int AW = 12,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_l,
  input  logic          we_l,
  input  logic          re_l,
  input  logic [AW-1:0] addr_l,
  input  logic [DW-1:0] wdat_l,
  input  logic          en_r,
  input  logic          we_r,
  input  logic          re_r,
  input  logic [AW-1:0] addr_r,
  input  logic [DW-1:0] wdat_r,
  output logic [DW-1:0] rdat_l,
  output logic [DW-1:0] rdat_r,
  output logic          clash
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic wr_l, wr_r;
  assign wr_l = en_l && we_l;
  assign wr_r = en_r && we_r;

  // Right first, left last: left data survives a same-address write.
  always_ff @(posedge clk) begin
    if (wr_r) mem[addr_r] <= wdat_r;
    if (wr_l) mem[addr_l] <= wdat_l;
  end

  // Read-first: a read at the same edge as a write sees the old word.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdat_l <= '0;
    end else if (en_l && re_l) begin
      rdat_l <= mem[addr_l];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdat_r <= '0;
    end else if (en_r && re_r) begin
      rdat_r <= mem[addr_r];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) clash <= 1'b0;
    else     clash <= wr_l && wr_r && (addr_l == addr_r);
  end

  // R9: in the clash cycle the array holds the left word
  p_clash_left_wins_r9: assert property (@(posedge clk) disable iff (rst)
    clash |-> (mem[$past(addr_l)] == $past(wdat_l)));

endmodule

// File: rtl/dpram_port_out.sv
module dpram_port_out
  import dpram_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cke,
  input  port_op_e      op,
  input  logic          pipe_mode,
  input  logic          oe_n,
  input  logic [DW-1:0] rdat,
  output logic [DW-1:0] dout,
  output logic          dout_en
);
  logic          drv_ft;
  logic          drv_pp;
  logic [DW-1:0] pp_dat;

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_ft <= 1'b0;
      drv_pp <= 1'b0;
      pp_dat <= '0;
    end else if (cke) begin
      drv_ft <= (op == OP_READ);
      drv_pp <= drv_ft && (op != OP_IDLE);
      pp_dat <= rdat;
    end
  end

  logic drv_sel;
  assign drv_sel = pipe_mode ? drv_pp : drv_ft;
  assign dout    = pipe_mode ? pp_dat : rdat;
  assign dout_en = drv_sel && !oe_n;

  // R2: a write slot is never driven
  p_write_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (cke && op == OP_WRITE) |=> !drv_ft);

  // R6: deselect undrives the flow-through state
  p_deselect_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (cke && op == OP_IDLE) |=> (!drv_ft && !drv_pp));

  // R6: pipelined drive rises only after a read was in flight
  p_pipe_reopen_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_pp) |-> ($past(drv_ft) && $past(cke)));

  // R5: a stalled edge leaves the output pipeline untouched
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !cke |=> ($stable(drv_ft) && $stable(drv_pp) && $stable(pp_dat)));

endmodule

// File: rtl/dpram_dual.sv
module dpram_dual
  import dpram_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdat,
  input  logic          l_rw_n,
  input  logic          l_ce_n,
  input  logic          l_cke_n,
  input  logic          l_oe_n,
  output logic [DW-1:0] l_rdat,
  output logic          l_rdat_vld,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdat,
  input  logic          r_rw_n,
  input  logic          r_ce_n,
  input  logic          r_cke_n,
  input  logic          r_oe_n,
  input  logic          r_pipe,
  output logic [DW-1:0] r_rdat,
  output logic          r_rdat_vld,
  output logic          wr_clash
);
  localparam int NPORT = 2;

  logic          ce_n_v  [NPORT];
  logic          rw_n_v  [NPORT];
  logic          cke_v   [NPORT];
  logic          oe_n_v  [NPORT];
  logic          pipe_v  [NPORT];
  logic [DW-1:0] rdat_v  [NPORT];
  logic [DW-1:0] dout_v  [NPORT];
  logic          den_v   [NPORT];
  port_op_e      op_v    [NPORT];

  assign ce_n_v[0] = l_ce_n;   assign ce_n_v[1] = r_ce_n;
  assign rw_n_v[0] = l_rw_n;   assign rw_n_v[1] = r_rw_n;
  assign cke_v[0]  = !l_cke_n; assign cke_v[1]  = !r_cke_n;
  assign oe_n_v[0] = l_oe_n;   assign oe_n_v[1] = r_oe_n;
  assign pipe_v[0] = 1'b1;     assign pipe_v[1] = r_pipe;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign op_v[p] = op_of(ce_n_v[p], rw_n_v[p]);

    dpram_port_out #(.DW(DW)) u_out (
      .clk       (clk),
      .rst       (rst),
      .cke       (cke_v[p]),
      .op        (op_v[p]),
      .pipe_mode (pipe_v[p]),
      .oe_n      (oe_n_v[p]),
      .rdat      (rdat_v[p]),
      .dout      (dout_v[p]),
      .dout_en   (den_v[p])
    );
  end

  logic [DW-1:0] arr_rd_l, arr_rd_r;

  dpram_array #(.AW(AW), .DW(DW)) u_array (
    .clk    (clk),
    .rst    (rst),
    .en_l   (cke_v[0]),
    .we_l   (op_v[0] == OP_WRITE),
    .re_l   (op_v[0] == OP_READ),
    .addr_l (l_addr),
    .wdat_l (l_wdat),
    .en_r   (cke_v[1]),
    .we_r   (op_v[1] == OP_WRITE),
    .re_r   (op_v[1] == OP_READ),
    .addr_r (r_addr),
    .wdat_r (r_wdat),
    .rdat_l (arr_rd_l),
    .rdat_r (arr_rd_r),
    .clash  (wr_clash)
  );

  assign rdat_v[0] = arr_rd_l;
  assign rdat_v[1] = arr_rd_r;

  assign l_rdat     = dout_v[0];
  assign l_rdat_vld = den_v[0];
  assign r_rdat     = dout_v[1];
  assign r_rdat_vld = den_v[1];

endmodule

// File: tb/dpram_dual_tb.sv
module dpram_dual_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [11:0] addr [2];
  logic [8:0]  wdat [2];
  logic        rw_n [2];
  logic        ce_n [2];
  logic        cke_n[2];
  logic        oe_n [2];
  logic        r_pipe;
  logic [8:0]  l_rdat, r_rdat;
  logic        l_vld, r_vld, clash;

  dpram_dual u_dut (
    .clk(clk), .rst(rst),
    .l_addr(addr[0]), .l_wdat(wdat[0]), .l_rw_n(rw_n[0]), .l_ce_n(ce_n[0]),
    .l_cke_n(cke_n[0]), .l_oe_n(oe_n[0]), .l_rdat(l_rdat), .l_rdat_vld(l_vld),
    .r_addr(addr[1]), .r_wdat(wdat[1]), .r_rw_n(rw_n[1]), .r_ce_n(ce_n[1]),
    .r_cke_n(cke_n[1]), .r_oe_n(oe_n[1]), .r_pipe(r_pipe),
    .r_rdat(r_rdat), .r_rdat_vld(r_vld), .wr_clash(clash)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference
  logic [8:0] mm [int];
  logic [8:0] ft_d [2], pp_d [2];
  bit         ft_v [2], pp_v [2], ft_k [2], pp_k [2];
  bit         clash_m;

  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < 2; p++) begin
        ft_d[p] = 0; pp_d[p] = 0; ft_v[p] = 0; pp_v[p] = 0;
        ft_k[p] = 1; pp_k[p] = 1;
      end
      clash_m = 0;
    end else begin
      bit w0, w1;
      for (int p = 0; p < 2; p++) begin
        if (!cke_n[p]) begin
          bit rd;
          rd = !ce_n[p] && rw_n[p];
          pp_v[p] = ft_v[p] && !ce_n[p];
          pp_d[p] = ft_d[p];
          pp_k[p] = ft_k[p];
          if (rd) begin
            if (mm.exists(int'(addr[p]))) begin
              ft_d[p] = mm[int'(addr[p])]; ft_k[p] = 1;
            end else ft_k[p] = 0;
          end
          ft_v[p] = rd;
        end
      end
      w0 = !cke_n[0] && !ce_n[0] && !rw_n[0];
      w1 = !cke_n[1] && !ce_n[1] && !rw_n[1];
      if (w1) mm[int'(addr[1])] = wdat[1];
      if (w0) mm[int'(addr[0])] = wdat[0];
      clash_m = w0 && w1 && (addr[0] == addr[1]);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    for (int p = 0; p < 2; p++) begin
      bit pm, een, known;
      logic [8:0] ed;
      pm    = (p == 0) ? 1'b1 : r_pipe;
      een   = (pm ? pp_v[p] : ft_v[p]) && !oe_n[p];
      ed    = pm ? pp_d[p] : ft_d[p];
      known = pm ? pp_k[p] : ft_k[p];
      chk(((p == 0) ? l_vld : r_vld) == een,
          $sformatf("%s model drive port%0d", cur_req, p),
          (p == 0) ? l_vld : r_vld, een);
      if (een && known)
        chk(((p == 0) ? l_rdat : r_rdat) == ed,
            $sformatf("%s model data port%0d", cur_req, p),
            (p == 0) ? l_rdat : r_rdat, ed);
    end
    chk(clash == clash_m, {cur_req, " model clash"}, clash, clash_m);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
    compare();
  endtask

  function automatic logic [8:0] f(input int a);
    return 9'((a * 37 + 5) & 32'h1FF);
  endfunction

  task automatic idle(input int p);
    ce_n[p] = 1; rw_n[p] = 1; cke_n[p] = 0;
  endtask

  task automatic op(input int p, input bit wr, input int a, input int d);
    ce_n[p] = 0; rw_n[p] = !wr; cke_n[p] = 0; addr[p] = 12'(a); wdat[p] = 9'(d);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      addr[p] = 0; wdat[p] = 0; oe_n[p] = 0; idle(p);
    end
    r_pipe = 0;
    rst = 1;
    step(); step();
    // R1 reset state
    chk(!l_vld && !r_vld && !clash, "R1 reset outputs", {l_vld, r_vld, clash}, 0);
    rst = 0;
    step();
    chk(!l_vld && !r_vld && !clash, "R1 after release", {l_vld, r_vld, clash}, 0);

    // R2 fill addresses 0..15 from the left port
    cur_req = "R2";
    for (int a = 0; a < 16; a++) begin
      op(0, 1, a, f(a));
      step();
      chk(!l_vld, "R2 write slot undriven", l_vld, 0);
    end
    idle(0);
    step();

    // R3 right flow-through read
    cur_req = "R3";
    op(1, 0, 3, 0);
    step();
    chk(r_vld && r_rdat == f(3), "R3 flow read addr3", r_rdat, f(3));

    // R4 / R6 left pipelined read from idle
    cur_req = "R4";
    op(0, 0, 7, 0);
    step();
    chk(!l_vld, "R6 pipe not driven after one low edge", l_vld, 0);
    op(0, 0, 8, 0);
    step();
    chk(l_vld && l_rdat == f(7), "R4 pipe read addr7", l_rdat, f(7));
    idle(0);
    step();
    chk(!l_vld, "R6 pipe deselect undrives", l_vld, 0);

    // R5 stall on the right port
    cur_req = "R5";
    op(1, 0, 2, 0);
    step();
    op(1, 1, 2, 0);
    cke_n[1] = 1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(r_vld && r_rdat == f(2), "R5 stalled output holds", r_rdat, f(2));
    end
    op(1, 0, 2, 0);
    step();
    chk(r_rdat == f(2), "R5 stalled write ignored", r_rdat, f(2));

    // R7 asynchronous output enable
    cur_req = "R7";
    oe_n[1] = 1; #1;
    chk(!r_vld, "R7 oe high undrives", r_vld, 0);
    oe_n[1] = 0; #1;
    chk(r_vld, "R7 oe low drives again", r_vld, 1);

    // R6 flow deselect
    cur_req = "R6";
    idle(1);
    step();
    chk(!r_vld, "R6 flow deselect undrives", r_vld, 0);

    // R8 write/read same address across ports
    cur_req = "R8";
    op(0, 1, 4, 9'h0AA);
    op(1, 0, 4, 0);
    step();
    chk(r_rdat == f(4), "R8 read sees old word", r_rdat, f(4));
    idle(0);
    step();
    chk(r_rdat == 9'h0AA, "R8 next read sees new word", r_rdat, 9'h0AA);

    // R9 double write
    cur_req = "R9";
    op(0, 1, 9, 9'h111);
    op(1, 1, 9, 9'h022);
    step();
    chk(clash, "R9 clash pulse", clash, 1);
    idle(0); idle(1);
    step();
    chk(!clash, "R9 clash one cycle", clash, 0);
    op(1, 0, 9, 0);
    step();
    chk(r_rdat == 9'h111, "R9 left word stored", r_rdat, 9'h111);

    // R10 random traffic, flow then pipelined right port
    for (int ph = 0; ph < 2; ph++) begin
      cur_req = "R10";
      rst = 1; idle(0); idle(1);
      r_pipe = ph[0];
      step(); step();
      rst = 0;
      for (int i = 0; i < 1500; i++) begin
        for (int p = 0; p < 2; p++) begin
          cke_n[p] = ($urandom % 8) == 0;
          ce_n[p]  = ($urandom % 5) == 0;
          rw_n[p]  = ($urandom % 3) != 0;
          addr[p]  = 12'($urandom % 16);
          wdat[p]  = 9'($urandom);
          oe_n[p]  = ($urandom % 10) == 0;
        end
        step();
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule